// File: doc/BRIEF.md
# NAND flash bus cycle generator

This block sits between a simple host request channel and the pins of a NAND flash device. Each accepted host request becomes one or more bus cycles on the flash pins. A request can go to one of three windows. A command-window write issues a byte with the command latch strobe raised. An address-window write does the same with the address latch strobe raised. A data-window access is a plain read or write cycle. A 32-bit data write is cut into byte or halfword cycles according to the programmed bus width.

Every bus cycle runs through a fixed sequence of phases, and each phase length is programmable in clock cycles. Setup comes first, with chip enable active and the strobes idle. The active-wait phase holds the write or read strobe low. In the hold phase the strobes are back high and the write data is still driven. The hi-Z phase releases the data bus. There are two timing sets: one for common-memory requests and one for attribute-memory requests. A separate delay can be added before a read that directly follows a command cycle, and another before a read that directly follows an address cycle. The device's ready/busy line is synchronised and can hold off data cycles.

Configuration is loaded through a write-only register port: one control word and two timing words. The host side uses a valid/ready handshake. A one-cycle response pulse marks the end of the request, and carries the read data when the request was a read.

Top module: `nand_cycle_gen`

## Requirements
- R1: After reset, chip enable is inactive (`nand_ce_n`=1), both strobes are high, both latch strobes are low, `nand_dq_oe`=0, `rsp_valid`=0 and `req_ready`=0.
- R2: `cfg_sel`=0 writes the control word. Its bits are: bit 0 hold-off, bit 1 wait-on, bit 2 enable, bit 3 NAND device type, bit 4 width (0 = 8-bit, 1 = 16-bit). `nand_ce_n` is the inverse of bit 2. A request is accepted only while bit 2 and bit 3 are 1 and bit 0 is 0.
- R3: `cfg_sel`=1 writes the common timing word and `cfg_sel`=2 writes the attribute timing word. In each word, bits 7:0 set the setup phase, 15:8 the active-wait phase, 23:16 the hold phase and 31:24 the hi-Z phase, all in clock cycles. A setup, wait or hold value of 0 acts as 1. A hi-Z value of 0 skips that phase.
- R4: A write with `req_space`=1 (command) gives one cycle. `nand_cle` is high through setup, wait and hold. `nand_we_n` is low for the wait phase. The low byte of `req_wdata` is on `nand_dq_out[7:0]`. A command request is always a write cycle.
- R5: A write with `req_space`=2 (address) gives one cycle of the same shape, with `nand_ale` high in place of `nand_cle`.
- R6: A data-window write (`req_space` 0 or 3) in 8-bit mode gives four byte cycles, least significant byte first. In 16-bit mode it gives two halfword cycles, low half first. Consecutive cycles are separated by hold, hi-Z and setup.
- R7: A data-window read gives one cycle with `nand_re_n` low for the wait phase. `nand_dq_in` is sampled on the clock edge that ends the wait phase, which is when RE rises. The sample is zero-extended (bits 7:0 in 8-bit mode, bits 15:0 in 16-bit mode) and returned on `rsp_rdata`.
- R8: `req_ready` is high only when no cycle is in progress. `rsp_valid` pulses for one clock in the cycle after the last hold phase of a request ends. The response latency in clocks from acceptance is T + n·(S+W+H) + (n−1)·Z + 1.
- R9: With wait-on set, a data-window request is not accepted while the synchronised `nand_rb` is low. Command and address requests are not affected.
- R10: A data read that directly follows a command request waits control bits 12:9 extra cycles before its setup phase. One that directly follows an address request waits control bits 16:13 extra cycles.
- R11: `req_attr`=1 makes the request use the attribute timing word. `req_attr`=0 uses the common timing word.
- R12: During the hi-Z phase `nand_dq_oe` is low and no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 control, 1 common timing, 2 attribute timing |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted this cycle when high with valid |
| req_write | input | 1 | 1 write, 0 read |
| req_space | input | 2 | 0/3 data, 1 command, 2 address |
| req_attr | input | 1 | Use attribute timing word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, zero-extended |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 16 | Data bus out |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | 16 | Data bus in |
| nand_rb | input | 1 | Ready/busy, high when ready |

## Verification
The hardest case to reach is the read turnaround delay. It only appears when a data read comes directly after a command or address request, and which field applies depends on which of the two came last. The stimulus therefore runs command-then-read and address-then-address-then-read sequences, and also a read that follows another data access, where no delay is expected. The gap between acceptance and the fall of RE is measured and compared. The ready/busy hold-off is reached by lowering the pin with wait-on set. The test then checks that a data request stays stalled while a command request still goes through.

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [1:0]  req_space,
  input  logic        req_attr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [15:0] nand_dq_out,
  output logic        nand_dq_oe,
  input  logic [15:0] nand_dq_in,
  input  logic        nand_rb
);
  localparam logic [1:0] SP_DATA = 2'd0, SP_CMD = 2'd1, SP_ADR = 2'd2;

  typedef enum logic [2:0] {IDLE, TURN, SETUP, WAIT, HOLD, HIZ} state_t;

  function automatic logic [7:0] at_least1(input logic [7:0] f);
    return (f == 8'd0) ? 8'd1 : f;
  endfunction

  state_t      st;
  logic [7:0]  cnt;
  logic [16:0] ctrl;
  logic [31:0] tim_c, tim_a, tim;
  logic [31:0] wdata;
  logic [1:0]  cur_sp, prev_sp, beat, last_beat;
  logic        cur_wr, more;
  logic [1:0]  rb_s;

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[31:17], ctrl[8:5]};

  wire [1:0]  sp       = (req_space == SP_CMD || req_space == SP_ADR) ? req_space : SP_DATA;
  wire        latch    = (sp != SP_DATA);
  wire        go_ok    = ctrl[2] & ctrl[3] & ~ctrl[0];
  wire        rb_ok    = ~ctrl[1] | rb_s[1] | latch;
  wire [31:0] sel_tim  = req_attr ? tim_a : tim_c;
  wire [3:0]  turn     = (latch || req_write) ? 4'd0 :
                         (prev_sp == SP_CMD) ? ctrl[12:9] :
                         (prev_sp == SP_ADR) ? ctrl[16:13] : 4'd0;
  wire        on_bus   = (st == SETUP) || (st == WAIT) || (st == HOLD);
  wire        accept   = req_valid & req_ready;

  assign req_ready   = (st == IDLE) & go_ok & rb_ok;
  assign nand_ce_n   = ~ctrl[2];
  assign nand_cle    = on_bus & (cur_sp == SP_CMD);
  assign nand_ale    = on_bus & (cur_sp == SP_ADR);
  assign nand_we_n   = ~((st == WAIT) & cur_wr);
  assign nand_re_n   = ~((st == WAIT) & ~cur_wr);
  assign nand_dq_oe  = on_bus & cur_wr;
  assign nand_dq_out = (ctrl[4] && cur_sp == SP_DATA) ? (beat[0] ? wdata[31:16] : wdata[15:0])
                                                       : {8'h00, wdata[8*beat +: 8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; ctrl <= '0; tim_c <= '0; tim_a <= '0; tim <= '0;
      wdata <= '0; cur_sp <= SP_DATA; prev_sp <= SP_DATA; beat <= '0; last_beat <= '0;
      cur_wr <= 1'b0; more <= 1'b0; rb_s <= '0; rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rb_s <= {rb_s[0], nand_rb};
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: ctrl  <= cfg_wdata[16:0];
          2'd1: tim_c <= cfg_wdata;
          2'd2: tim_a <= cfg_wdata;
          default: ;
        endcase
      end
      case (st)
        IDLE: if (accept) begin
          cur_sp <= sp; prev_sp <= sp; cur_wr <= req_write | latch;
          tim <= sel_tim; wdata <= req_wdata; beat <= '0;
          last_beat <= (latch || !req_write) ? 2'd0 : (ctrl[4] ? 2'd1 : 2'd3);
          if (turn != 4'd0) begin st <= TURN; cnt <= {4'd0, turn} - 8'd1; end
          else begin st <= SETUP; cnt <= at_least1(sel_tim[7:0]) - 8'd1; end
        end
        TURN:  if (cnt == 0) begin st <= SETUP; cnt <= at_least1(tim[7:0]) - 8'd1; end
               else cnt <= cnt - 8'd1;
        SETUP: if (cnt == 0) begin st <= WAIT; cnt <= at_least1(tim[15:8]) - 8'd1; end
               else cnt <= cnt - 8'd1;
        WAIT:  if (cnt == 0) begin
                 st <= HOLD; cnt <= at_least1(tim[23:16]) - 8'd1;
                 if (!cur_wr) rsp_rdata <= ctrl[4] ? {16'h0, nand_dq_in} : {24'h0, nand_dq_in[7:0]};
               end else cnt <= cnt - 8'd1;
        HOLD:  if (cnt == 0) begin
                 rsp_valid <= (beat == last_beat);
                 more <= (beat != last_beat);
                 if (beat != last_beat) beat <= beat + 2'd1;
                 if (tim[31:24] != 8'd0) begin st <= HIZ; cnt <= tim[31:24] - 8'd1; end
                 else if (beat != last_beat) begin st <= SETUP; cnt <= at_least1(tim[7:0]) - 8'd1; end
                 else st <= IDLE;
               end else cnt <= cnt - 8'd1;
        HIZ:   if (cnt == 0) begin
                 if (more) begin st <= SETUP; cnt <= at_least1(tim[7:0]) - 8'd1; end
                 else st <= IDLE;
               end else cnt <= cnt - 8'd1;
        default: st <= IDLE;
      endcase
    end
  end

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (st != IDLE));
  assert_rsp_after_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(st) == HOLD);
  assert_strobe_after_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nand_we_n) || $fell(nand_re_n)) |-> $past(st) == SETUP);
  assert_cle_spans_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n && nand_cle) |=> nand_cle);
  assert_data_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nand_we_n) |-> nand_dq_oe);
  assert_hiz_released_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HIZ) |-> (!nand_dq_oe && !req_ready));
endmodule

// File: tb/test_nand_cycle_gen.sv
`timescale 1ns/1ps
module test_nand_cycle_gen;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [31:0] cfg_wdata = 0;
  logic req_valid = 0, req_write = 0, req_attr = 0; logic [1:0] req_space = 0;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid; logic [31:0] rsp_rdata;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [15:0] nand_dq_out; logic [15:0] nand_dq_in = 16'hA55C; logic nand_rb = 1;

  always #2.5 clk = ~clk;

  nand_cycle_gen i_nand_cycle_gen (.*);

  typedef struct packed { logic [1:0] kind; logic [15:0] data; logic [7:0] lead; logic [7:0] low; } item_t;
  item_t exp_q[$];
  int errors = 0, checks = 0;
  logic [16:0] m_ctrl = 0; logic [31:0] m_tc = 0, m_ta = 0; logic [1:0] m_prev = 0;

  task automatic chk(input logic ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp); end
  endtask

  // monitor: rebuilds each strobe pulse from the pins and compares with the queue
  logic was_lo = 0; int lead = 0; item_t cur;
  always @(negedge clk) if (rst_n) begin
    automatic logic lo = !nand_we_n || !nand_re_n;
    if (lo) begin
      if (!was_lo) begin
        cur.lead = lead[7:0]; cur.low = 0;
        cur.kind = !nand_we_n ? (nand_cle ? 2'd1 : nand_ale ? 2'd2 : 2'd0) : 2'd3;
        cur.data = !nand_we_n ? nand_dq_out : 16'h0;
      end
      cur.low = cur.low + 8'd1;
    end else if (was_lo) begin
      lead = 1;
      if (exp_q.size() == 0) chk(0, "R4", "unexpected bus cycle", cur, 0);
      else begin
        automatic item_t e = exp_q.pop_front();
        automatic string r = e.kind == 1 ? "R4" : e.kind == 2 ? "R5" : e.kind == 0 ? "R6" : "R7";
        chk(cur == e, r, "bus cycle {kind,data,lead,low}", cur, e);
      end
    end else if (req_valid && req_ready) lead = 0;
    else lead++;
    was_lo = lo;
  end

  function automatic int len1(input logic [7:0] f); return f == 0 ? 1 : int'(f); endfunction

  task automatic cfg(input logic [1:0] sel, input logic [31:0] v);
    @(posedge clk); #1 cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    @(posedge clk); #1 cfg_we = 0;
    if (sel == 0) m_ctrl = v[16:0]; else if (sel == 1) m_tc = v; else if (sel == 2) m_ta = v;
  endtask

  // driver: pushes expected bus cycles, runs the handshake, checks latency and response
  task automatic do_req(input logic wr, input logic [1:0] sp, input logic attr, input logic [31:0] wd);
    automatic logic [31:0] t = attr ? m_ta : m_tc;
    automatic int s = len1(t[7:0]), w = len1(t[15:8]), h = len1(t[23:16]), z = int'(t[31:24]);
    automatic logic is_latch = (sp == 1 || sp == 2);
    automatic int n = (is_latch || !wr) ? 1 : (m_ctrl[4] ? 2 : 4);
    automatic int tr = 0; automatic int lat = 0; automatic int exp_lat;
    automatic logic [1:0] nsp = is_latch ? sp : 2'd0;
    if (!wr && !is_latch) tr = m_prev == 1 ? int'(m_ctrl[12:9]) : m_prev == 2 ? int'(m_ctrl[16:13]) : 0;
    for (int b = 0; b < n; b++) begin
      automatic item_t e;
      e.kind = (!wr && !is_latch) ? 2'd3 : nsp;
      e.data = (!wr && !is_latch) ? 16'h0 : (m_ctrl[4] && !is_latch) ? wd[16*b +: 16] : {8'h0, wd[8*b +: 8]};
      e.lead = 8'(b == 0 ? tr + s : h + z + s);
      e.low = 8'(w);
      exp_q.push_back(e);
    end
    exp_lat = tr + n * (s + w + h) + (n - 1) * z + 1;
    @(posedge clk); #1 req_valid = 1; req_write = wr; req_space = sp; req_attr = attr; req_wdata = wd;
    @(negedge clk); while (!req_ready) @(negedge clk);
    @(posedge clk); #1 req_valid = 0;
    m_prev = nsp;
    do begin @(negedge clk); lat++; end while (!rsp_valid && lat < 2000);
    chk(lat == exp_lat, "R8", "response latency", lat, exp_lat);
    if (z > 0) chk(!req_ready && !nand_dq_oe, "R12", "hi-Z phase ready/oe", {req_ready, nand_dq_oe}, 0);
    if (!wr && !is_latch) begin
      automatic logic [31:0] er = m_ctrl[4] ? {16'h0, nand_dq_in} : {24'h0, nand_dq_in[7:0]};
      chk(rsp_rdata == er, "R7", "read data", rsp_rdata, er);
    end
    @(negedge clk);
    chk(!rsp_valid, "R8", "single-cycle response pulse", rsp_valid, 0);
    while (!(req_ready || !(m_ctrl[2] && m_ctrl[3]))) @(negedge clk);
  endtask

  task automatic expect_stall(input logic [1:0] sp, input string req);
    @(posedge clk); #1 req_valid = 1; req_write = 0; req_space = sp;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!req_ready && nand_re_n && nand_we_n, req, "stalled request", {req_ready, nand_re_n, nand_we_n}, 3'b011);
    end
    @(posedge clk); #1 req_valid = 0;
  endtask

  localparam logic [31:0] EN = 32'h4, DEV = 32'h8;
  localparam logic [31:0] CTRL8 = EN | DEV | (32'd3 << 9) | (32'd2 << 13);

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe && !rsp_valid,
        "R1", "pins during reset", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}, 6'b111000);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!req_ready && nand_ce_n, "R1", "ready/ce after reset", {req_ready, nand_ce_n}, 2'b01);

    cfg(1, 32'h01_02_03_02);
    cfg(2, 32'h00_01_05_01);
    cfg(0, CTRL8);
    @(negedge clk);
    chk(!nand_ce_n, "R2", "chip enable active", nand_ce_n, 0);

    do_req(1, 1, 0, 32'h0000_0070);          // R4 command
    do_req(0, 0, 0, 0);                      // R10 turnaround after command, R7 read
    do_req(0, 0, 0, 0);                      // R10 no delay after data
    do_req(1, 2, 0, 32'h12);                 // R5 address
    do_req(1, 2, 0, 32'h34);
    do_req(0, 0, 0, 0);                      // R10 delay after address
    do_req(1, 0, 0, 32'hDEAD_BEEF);          // R6 8-bit split
    do_req(1, 0, 1, 32'h1122_3344);          // R11 attribute timing
    do_req(1, 3, 0, 32'h0A0B_0C0D);          // R6 space code 3 is data
    cfg(0, CTRL8 | 32'h10);
    do_req(1, 0, 0, 32'hCAFE_F00D);          // R6 16-bit split
    nand_dq_in = 16'h93E1;
    do_req(0, 0, 0, 0);                      // R7 16-bit read
    cfg(1, 32'h0);
    do_req(1, 1, 0, 32'hFF);                 // R3 zero fields clamp, hi-Z skipped
    cfg(1, 32'h02_01_04_03);
    do_req(1, 2, 0, 32'h5A);                 // R3 longer phases

    cfg(0, CTRL8 | 32'h2);                   // R9 wait-on
    nand_rb = 0; repeat (3) @(posedge clk);
    expect_stall(0, "R9");
    do_req(1, 1, 0, 32'h90);                 // R9 command not held off
    nand_rb = 1; repeat (3) @(posedge clk);
    do_req(0, 0, 0, 0);                      // R9 released, R10 after command

    cfg(0, CTRL8 | 32'h1);                   // R2 hold-off bit
    expect_stall(1, "R2");
    cfg(0, CTRL8 & ~EN);                     // R2 enable clear
    @(negedge clk);
    chk(nand_ce_n, "R2", "chip deselected", nand_ce_n, 1);
    expect_stall(1, "R2");
    cfg(0, CTRL8 & ~DEV);                    // R2 device type clear
    expect_stall(2, "R2");
    cfg(0, CTRL8);
    do_req(1, 1, 1, 32'hEE);                 // R11 attribute set on command

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "all expected bus cycles seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule